// File: doc/BRIEF.md
# External Memory Address Port Multiplexer

This block decides, for every pin of two byte-wide ports of an 8051-style controller, whether the pin pulls low, pulls up strongly, pulls up weakly or floats. The low port is either a plain open-drain port or the bus that carries the low address byte and then the data byte. The high port is either a plain port with weak pull-ups or the source of the high address byte. The core states the kind of bus cycle, the phase within it, the 16-bit address, the byte to be written and the two port latches. The block turns these into per-pin pad enables.

All pad enables come from registers. A change at the inputs reaches the pads on the next clock edge, and when a bus access ends both ports go back to their latch values on the following clock. The block also returns read data for each port. A normal read gives the sampled pad level. A read-modify-write read gives the latch value.

Top module: `portmux_top`

## Requirements
- R1: While reset is asserted, and after it until the first clock edge with reset released, every drive-low, weak-pullup and strong-pullup output and both read-data outputs are all zeros.
- R2: With access type 0 (none), the low port behaves as open drain: a pin pulls low where its latch bit is 0, and neither pull-up is enabled on any low-port pin.
- R3: With access type 0 (none), the high port pulls low where its latch bit is 0, enables the weak pull-up where its latch bit is 1, and enables no strong pull-up.
- R4: In the address phase (busData = 0) of access types 1, 2 or 3, the low port emits address bits [7:0]: drive-low where a bit is 0, strong pull-up where it is 1, no weak pull-up.
- R5: In the data phase (busData = 1) of a data access (type 2 or 3) with busWrite = 1, the low port drives the write byte in both polarities: drive-low on 0 bits, strong pull-up on 1 bits.
- R6: In the data phase of a data access with busWrite = 0, and in the data phase of a code fetch (type 1) whatever busWrite is, every low-port enable is 0, so the port floats.
- R7: During access type 1 (code fetch) or type 2 (16-bit pointer data access), in both phases, the high port emits address bits [15:8] with drive-low on 0 bits, strong pull-up on 1 bits and no weak pull-up.
- R8: During access type 3 (8-bit pointer data access), the high port shows its own latch in the R3 manner and never emits the address.
- R9: Every pad enable reflects the inputs sampled at the previous rising clock edge. One clock after the access type returns to 0, both ports show their latch values again.
- R10: Read data for each port is registered. It equals that port's pad input sampled at the previous edge when rmwRead = 0, and that port's latch when rmwRead = 1.
- R11: On no pin is drive-low enabled together with either pull-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accType | input | 2 | 0 none, 1 code fetch, 2 16-bit pointer data, 3 8-bit pointer data |
| busData | input | 1 | 0 address phase, 1 data phase |
| busWrite | input | 1 | Data phase is a write |
| rmwRead | input | 1 | Read returns the latch instead of the pad |
| addr | input | 2*PORT_W | Bus address |
| wrData | input | PORT_W | Byte driven in a write data phase |
| lowLatch | input | PORT_W | Low port latch |
| highLatch | input | PORT_W | High port latch |
| lowPad | input | PORT_W | Low port pad levels |
| highPad | input | PORT_W | High port pad levels |
| lowDriveLow | output | PORT_W | Low port pull-down enables |
| lowWeakUp | output | PORT_W | Low port weak pull-up enables |
| lowStrongUp | output | PORT_W | Low port strong pull-up enables |
| highDriveLow | output | PORT_W | High port pull-down enables |
| highWeakUp | output | PORT_W | High port weak pull-up enables |
| highStrongUp | output | PORT_W | High port strong pull-up enables |
| lowRead | output | PORT_W | Low port read data |
| highRead | output | PORT_W | High port read data |

## Verification
The bench builds the block with the default PORT_W of 8, so the address is 16 bits and each port byte can be set to distinct patterns such as 0xA5 and 0x3C. With these patterns, swapping the address halves, swapping the latches, or confusing the write byte with the address shows up on specific pins. Directed steps walk each access type through both phases and both write polarities, then return to idle to check the recovery on the next clock. A run of random bus steps follows, each compared one clock later.

// File: rtl/portmux_pkg.sv
package portmux_pkg;
  typedef enum logic [1:0] {
    ACC_NONE   = 2'd0,
    ACC_CODE   = 2'd1,
    ACC_WIDE   = 2'd2,
    ACC_NARROW = 2'd3
  } accKind_e;

  typedef struct packed {
    logic lowAddr;
    logic lowWrite;
    logic lowRelease;
    logic highAddr;
    logic readLatch;
  } muxStrobe_t;
endpackage

// File: rtl/portmux_ctrl.sv
module portmux_ctrl
  import portmux_pkg::*;
(
  input  logic [1:0]  accType,
  input  logic        busData,
  input  logic        busWrite,
  input  logic        rmwRead,
  output muxStrobe_t  strobe
);
  accKind_e kind;
  logic     active;
  logic     dataAccess;

  assign kind       = accKind_e'(accType);
  assign active     = (kind != ACC_NONE);
  assign dataAccess = (kind == ACC_WIDE) || (kind == ACC_NARROW);

  always_comb begin
    strobe            = '0;
    strobe.lowAddr    = active && !busData;
    strobe.lowWrite   = active && busData && dataAccess && busWrite;
    strobe.lowRelease = active && busData && !(dataAccess && busWrite);
    strobe.highAddr   = (kind == ACC_CODE) || (kind == ACC_WIDE);
    strobe.readLatch  = rmwRead;
  end
endmodule

// File: rtl/portmux_datapath.sv
module portmux_datapath
  import portmux_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  muxStrobe_t            strobe,
  input  logic [2*PORT_W-1:0]   addr,
  input  logic [PORT_W-1:0]     wrData,
  input  logic [PORT_W-1:0]     lowLatch,
  input  logic [PORT_W-1:0]     highLatch,
  input  logic [PORT_W-1:0]     lowPad,
  input  logic [PORT_W-1:0]     highPad,
  output logic [PORT_W-1:0]     lowDriveLow,
  output logic [PORT_W-1:0]     lowWeakUp,
  output logic [PORT_W-1:0]     lowStrongUp,
  output logic [PORT_W-1:0]     highDriveLow,
  output logic [PORT_W-1:0]     highWeakUp,
  output logic [PORT_W-1:0]     highStrongUp,
  output logic [PORT_W-1:0]     lowRead,
  output logic [PORT_W-1:0]     highRead
);
  localparam int ADDR_W = 2 * PORT_W;

  logic [PORT_W-1:0] addrLo;
  logic [PORT_W-1:0] addrHi;
  logic [PORT_W-1:0] nextLowDl, nextLowSu;
  logic [PORT_W-1:0] nextHighDl, nextHighWu, nextHighSu;

  assign addrLo = addr[PORT_W-1:0];
  assign addrHi = addr[ADDR_W-1:PORT_W];

  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    // low port: address, write data, released, or open-drain latch
    assign nextLowDl[i] = strobe.lowAddr    ? ~addrLo[i] :
                          strobe.lowWrite   ? ~wrData[i] :
                          strobe.lowRelease ? 1'b0       :
                                              ~lowLatch[i];
    assign nextLowSu[i] = strobe.lowAddr    ? addrLo[i]  :
                          strobe.lowWrite   ? wrData[i]  :
                                              1'b0;
    // high port: address byte with strong pull-up, else latch with weak pull-up
    assign nextHighDl[i] = strobe.highAddr ? ~addrHi[i] : ~highLatch[i];
    assign nextHighSu[i] = strobe.highAddr ?  addrHi[i] : 1'b0;
    assign nextHighWu[i] = strobe.highAddr ?  1'b0      : highLatch[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowDriveLow  <= '0;
      lowWeakUp    <= '0;
      lowStrongUp  <= '0;
      highDriveLow <= '0;
      highWeakUp   <= '0;
      highStrongUp <= '0;
      lowRead      <= '0;
      highRead     <= '0;
    end else begin
      lowDriveLow  <= nextLowDl;
      lowWeakUp    <= '0;
      lowStrongUp  <= nextLowSu;
      highDriveLow <= nextHighDl;
      highWeakUp   <= nextHighWu;
      highStrongUp <= nextHighSu;
      lowRead      <= strobe.readLatch ? lowLatch  : lowPad;
      highRead     <= strobe.readLatch ? highLatch : highPad;
    end
  end
endmodule

// File: rtl/portmux_top.sv
module portmux_top
  import portmux_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [1:0]            accType,
  input  logic                  busData,
  input  logic                  busWrite,
  input  logic                  rmwRead,
  input  logic [2*PORT_W-1:0]   addr,
  input  logic [PORT_W-1:0]     wrData,
  input  logic [PORT_W-1:0]     lowLatch,
  input  logic [PORT_W-1:0]     highLatch,
  input  logic [PORT_W-1:0]     lowPad,
  input  logic [PORT_W-1:0]     highPad,
  output logic [PORT_W-1:0]     lowDriveLow,
  output logic [PORT_W-1:0]     lowWeakUp,
  output logic [PORT_W-1:0]     lowStrongUp,
  output logic [PORT_W-1:0]     highDriveLow,
  output logic [PORT_W-1:0]     highWeakUp,
  output logic [PORT_W-1:0]     highStrongUp,
  output logic [PORT_W-1:0]     lowRead,
  output logic [PORT_W-1:0]     highRead
);
  muxStrobe_t strobe;

  portmux_ctrl u_ctrl (
    .accType  (accType),
    .busData  (busData),
    .busWrite (busWrite),
    .rmwRead  (rmwRead),
    .strobe   (strobe)
  );

  portmux_datapath #(.PORT_W(PORT_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .addr         (addr),
    .wrData       (wrData),
    .lowLatch     (lowLatch),
    .highLatch    (highLatch),
    .lowPad       (lowPad),
    .highPad      (highPad),
    .lowDriveLow  (lowDriveLow),
    .lowWeakUp    (lowWeakUp),
    .lowStrongUp  (lowStrongUp),
    .highDriveLow (highDriveLow),
    .highWeakUp   (highWeakUp),
    .highStrongUp (highStrongUp),
    .lowRead      (lowRead),
    .highRead     (highRead)
  );
endmodule

// File: rtl/portmux_checker.sv
module portmux_checker #(
  parameter int PORT_W = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [1:0]            accType,
  input logic                  busData,
  input logic                  busWrite,
  input logic                  rmwRead,
  input logic [2*PORT_W-1:0]   addr,
  input logic [PORT_W-1:0]     wrData,
  input logic [PORT_W-1:0]     lowLatch,
  input logic [PORT_W-1:0]     highLatch,
  input logic [PORT_W-1:0]     lowPad,
  input logic [PORT_W-1:0]     highPad,
  input logic [PORT_W-1:0]     lowDriveLow,
  input logic [PORT_W-1:0]     lowWeakUp,
  input logic [PORT_W-1:0]     lowStrongUp,
  input logic [PORT_W-1:0]     highDriveLow,
  input logic [PORT_W-1:0]     highWeakUp,
  input logic [PORT_W-1:0]     highStrongUp,
  input logic [PORT_W-1:0]     lowRead,
  input logic [PORT_W-1:0]     highRead
);
  a_r11_no_fight: assert property (@(posedge clk) disable iff (!rstN)
    ((lowDriveLow & (lowWeakUp | lowStrongUp)) == '0) &&
    ((highDriveLow & (highWeakUp | highStrongUp)) == '0));

  a_r2_idle_low_open_drain: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(accType) == 2'd0) |->
      (lowDriveLow == ~$past(lowLatch)) && (lowStrongUp == '0) && (lowWeakUp == '0));

  a_r8_narrow_high_latch: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(accType) == 2'd3) |->
      (highDriveLow == ~$past(highLatch)) && (highWeakUp == $past(highLatch)) &&
      (highStrongUp == '0));

  a_r7_high_address: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && ($past(accType) == 2'd1 || $past(accType) == 2'd2)) |->
      (highStrongUp == $past(addr[2*PORT_W-1:PORT_W])) && (highWeakUp == '0));

  a_r4_low_address: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(accType) != 2'd0 && !$past(busData)) |->
      (lowStrongUp == $past(addr[PORT_W-1:0])) && (lowDriveLow == ~$past(addr[PORT_W-1:0])));

  a_r6_low_released: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(busData) &&
     ($past(accType) == 2'd1 || ($past(accType) != 2'd0 && !$past(busWrite)))) |->
      (lowDriveLow == '0) && (lowStrongUp == '0));

  a_r10_read_source: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |->
      (lowRead == ($past(rmwRead) ? $past(lowLatch) : $past(lowPad))) &&
      (highRead == ($past(rmwRead) ? $past(highLatch) : $past(highPad))));
endmodule

bind portmux_top portmux_checker #(.PORT_W(PORT_W)) u_chk (
  .clk(clk), .rstN(rstN), .accType(accType), .busData(busData),
  .busWrite(busWrite), .rmwRead(rmwRead), .addr(addr), .wrData(wrData),
  .lowLatch(lowLatch), .highLatch(highLatch), .lowPad(lowPad), .highPad(highPad),
  .lowDriveLow(lowDriveLow), .lowWeakUp(lowWeakUp), .lowStrongUp(lowStrongUp),
  .highDriveLow(highDriveLow), .highWeakUp(highWeakUp), .highStrongUp(highStrongUp),
  .lowRead(lowRead), .highRead(highRead)
);

// File: tb/tb_portmux_top.sv
module tb_portmux_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0]   accType = '0;
  logic         busData = 1'b0, busWrite = 1'b0, rmwRead = 1'b0;
  logic [2*W-1:0] addr = '0;
  logic [W-1:0] wrData = '0, lowLatch = '1, highLatch = '1, lowPad = '0, highPad = '0;
  logic [W-1:0] lowDriveLow, lowWeakUp, lowStrongUp;
  logic [W-1:0] highDriveLow, highWeakUp, highStrongUp, lowRead, highRead;

  always #4 clk = ~clk;

  portmux_top #(.PORT_W(W)) dut (
    .clk(clk), .rstN(rstN), .accType(accType), .busData(busData),
    .busWrite(busWrite), .rmwRead(rmwRead), .addr(addr), .wrData(wrData),
    .lowLatch(lowLatch), .highLatch(highLatch), .lowPad(lowPad), .highPad(highPad),
    .lowDriveLow(lowDriveLow), .lowWeakUp(lowWeakUp), .lowStrongUp(lowStrongUp),
    .highDriveLow(highDriveLow), .highWeakUp(highWeakUp), .highStrongUp(highStrongUp),
    .lowRead(lowRead), .highRead(highRead)
  );

  typedef struct {
    logic [8*W-1:0] vec;   // {lDl,lWu,lSu,hDl,hWu,hSu,lRd,hRd}
    string          tag;
  } expItem_t;

  expItem_t expQ[$];
  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  function automatic logic [8*W-1:0] actualVec();
    return {lowDriveLow, lowWeakUp, lowStrongUp, highDriveLow, highWeakUp,
            highStrongUp, lowRead, highRead};
  endfunction

  // expected pad state from the requirements
  function automatic logic [8*W-1:0] model(logic [1:0] t, logic d, logic w, logic r,
      logic [2*W-1:0] a, logic [W-1:0] wd, logic [W-1:0] ll, logic [W-1:0] hl,
      logic [W-1:0] lp, logic [W-1:0] hp);
    logic [W-1:0] lDl, lSu, hDl, hWu, hSu;
    if (t == 2'd0) begin lDl = ~ll; lSu = '0; end                 // R2
    else if (!d) begin lDl = ~a[W-1:0]; lSu = a[W-1:0]; end       // R4
    else if (t != 2'd1 && w) begin lDl = ~wd; lSu = wd; end       // R5
    else begin lDl = '0; lSu = '0; end                            // R6
    if (t == 2'd1 || t == 2'd2) begin                             // R7
      hDl = ~a[2*W-1:W]; hSu = a[2*W-1:W]; hWu = '0;
    end else begin                                                // R3, R8
      hDl = ~hl; hSu = '0; hWu = hl;
    end
    return {lDl, {W{1'b0}}, lSu, hDl, hWu, hSu, r ? ll : lp, r ? hl : hp}; // R10
  endfunction

  task automatic step(input logic [1:0] t, input logic d, input logic w, input logic r,
      input logic [2*W-1:0] a, input logic [W-1:0] wd, input logic [W-1:0] ll,
      input logic [W-1:0] hl, input logic [W-1:0] lp, input logic [W-1:0] hp,
      input string tag);
    expItem_t it;
    @(negedge clk);
    accType = t; busData = d; busWrite = w; rmwRead = r; addr = a; wrData = wd;
    lowLatch = ll; highLatch = hl; lowPad = lp; highPad = hp;
    it.vec = model(t, d, w, r, a, wd, ll, hl, lp, hp);
    it.tag = tag;
    expQ.push_back(it);
  endtask

  // monitor: one clock after each driven step the registered pads are compared
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        compared++;
        if (actualVec() !== it.vec) begin
          mismatched++;
          $display("FAIL %s actual=%h expected=%h", it.tag, actualVec(), it.vec);
        end
      end
    end
  end

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    lowPad = 8'hFF; highPad = 8'hFF;
    @(negedge clk);
    // R1: reset state
    compared++;
    if (actualVec() !== '0) begin
      mismatched++;
      $display("FAIL R1 actual=%h expected=%h", actualVec(), {8*W{1'b0}});
    end
    rstN = 1'b1;
    // idle, R2 R3 R10
    step(2'd0, 0, 0, 0, 16'h1234, 8'h00, 8'hA5, 8'h3C, 8'h5A, 8'hC3, "R2/R3/R10");
    step(2'd0, 0, 0, 1, 16'h1234, 8'h00, 8'h0F, 8'hF0, 8'h5A, 8'hC3, "R2/R3/R10 rmw");
    // code fetch: R4 then R6 with write asserted, R7
    step(2'd1, 0, 0, 0, 16'hA55A, 8'h77, 8'h11, 8'h22, 8'h00, 8'h00, "R4/R7 code addr");
    step(2'd1, 1, 1, 0, 16'hA55A, 8'h77, 8'h11, 8'h22, 8'h96, 8'h69, "R6/R7 code data");
    // wide pointer write and read
    step(2'd2, 0, 1, 0, 16'h3CC3, 8'h81, 8'h44, 8'h55, 8'h00, 8'h00, "R4/R7 wide addr");
    step(2'd2, 1, 1, 0, 16'h3CC3, 8'h81, 8'h44, 8'h55, 8'h00, 8'h00, "R5/R7 wide write");
    step(2'd2, 1, 0, 0, 16'h3CC3, 8'h81, 8'h44, 8'h55, 8'hE7, 8'h00, "R6 wide read");
    // narrow pointer: high port shows latch
    step(2'd3, 0, 1, 0, 16'hFF0F, 8'h6D, 8'h99, 8'h5A, 8'h00, 8'h00, "R4/R8 narrow addr");
    step(2'd3, 1, 1, 0, 16'hFF0F, 8'h6D, 8'h99, 8'h5A, 8'h00, 8'h00, "R5/R8 narrow write");
    step(2'd3, 1, 0, 1, 16'hFF0F, 8'h6D, 8'h99, 8'h5A, 8'h12, 8'h34, "R6/R8/R10 narrow read");
    // access ends: latch back on next clock
    step(2'd0, 0, 0, 0, 16'hFFFF, 8'hFF, 8'hC6, 8'h39, 8'h00, 8'h00, "R9 return");
    step(2'd2, 0, 0, 0, 16'h0000, 8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00, "R4/R7 zero addr");
    step(2'd0, 0, 0, 0, 16'h0000, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF, "R9 all-ones latch");
    for (int k = 0; k < 40; k++) begin
      step(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 16'($urandom),
           8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
           "R9/R11 random");
    end
    repeat (3) @(negedge clk);
    report();
  end
endmodule